// File: doc/BRIEF.md
# Microcoded Multiply-of-Sum Datapath

This block computes F = E * (A + B) on 8-bit unsigned operands. It does not build the expression as one combinational cone. A single adder and a single multiplier are shared through a four-entry register file and a two-way multiplexer in front of the third register. A controller advances one register transfer per clock to move the operands through this datapath.

The controller is a small microcode ROM addressed by a 4-bit microprogram counter. Each ROM word carries an 8-bit control field (register load enables, the multiplexer select, the result-register load, the done flag and a wait-for-start flag) and a 4-bit next address. Address 0 is the idle word and waits for `start`. Addresses 1 to 4 are the four transfer steps. Address 5 raises `done` and then returns to idle.

The user holds A and B stable until the second clock edge after `start` is taken, and holds E stable until the fourth edge. The user then reads F while `done` is high, or at any later time before the next run.

Top module: `seqcalc_top`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge (synchronous, active low), the controller returns to idle, all four working registers and `f` clear to 0, and `done` reads 0 after that edge.
- R2: In idle, `start` sampled high at a rising edge begins a run, and `done` is 0 in the three cycles that follow. `done` rises after the fifth rising edge, counting the edge that sampled `start` as the first. With `start` low the block stays idle and `done` stays 0.
- R3: The result on `f` is the 16-bit product E * S, where S is the 8-bit sum register. `f` is valid in the same cycle that `done` is high.
- R4: The sum register is 8 bits wide, so S = (A + B) mod 256, and a carry out of the adder is dropped.
- R5: `done` is high for exactly one clock cycle per run.
- R6: `f` keeps its value after `done` falls, and changes only when a later run completes.
- R7: `start` has no effect while a run is in progress, and this includes the cycle in which `done` is high. Such a pulse produces no extra run and no extra `done`.
- R8: A and B are captured at the second rising edge of a run and E at the fourth. Changes to A and B after the second edge, and to E after the fourth, do not affect `f`.
- R9: If `start` is held high, runs follow one another, and `done` pulses once every 6 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run; only sampled in idle |
| a | input | 8 | First addend |
| b | input | 8 | Second addend |
| e | input | 8 | Multiplicand applied to the sum |
| done | output | 1 | One-cycle completion pulse |
| f | output | 16 | Full product E * ((A+B) mod 256) |

## Verification
The completion pulse and a new `start` request can land in the same cycle. At that point the microprogram is leaving address 5, and the new request must not be taken as a restart. The bench provokes this by watching for `done` and driving a single-cycle `start` in exactly that cycle. It also drives a second request in the middle of a run. It judges the result by requiring no further `done` over the following eight cycles, with `f` unchanged. A separate case holds `start` high continuously to show that a request made in idle right after completion is accepted, with a six-cycle period.

// File: rtl/seqcalc_pkg.sv
// Package: shared widths and microcode word layout for the multiply-of-sum block.
// Assumes a four-register file and a 4-bit microprogram address.
package seqcalc_pkg;
    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int NREG  = 4;
    localparam int DEPTH = 1 << AW;

    // Control field: 8 bits total
    typedef struct packed {
        logic            wait_start;  // hold address until start
        logic            done;        // completion flag
        logic            ld_f;        // capture full product
        logic            sel_add;     // 1: adder to R3, 0: multiplier to R3
        logic [NREG-1:0] ld_reg;      // bit i loads register i (R1 = bit 0)
    } ctrl_t;

    typedef struct packed {
        ctrl_t         ctrl;
        logic [AW-1:0] next;
    } uword_t;

    localparam logic [AW-1:0] IDLE_ADDR = '0;
endpackage

// File: rtl/seqcalc_rom.sv
// Microcode ROM: maps a microprogram address to a control field and next address.
// Assumes purely combinational lookup; unused addresses fall back to idle.
module seqcalc_rom
    import seqcalc_pkg::*;
(
    input  logic [AW-1:0] addr,
    output uword_t        word
);
    // Computes the word for one address
    function automatic uword_t lookup(input logic [AW-1:0] ad);
        uword_t w;
        w = '0;
        w.next = IDLE_ADDR;
        case (ad)
            4'd0: begin w.ctrl.wait_start = 1'b1;                  w.next = 4'd1; end
            4'd1: begin w.ctrl.ld_reg = 4'b0011;                   w.next = 4'd2; end
            4'd2: begin w.ctrl.ld_reg = 4'b0100; w.ctrl.sel_add = 1'b1; w.next = 4'd3; end
            4'd3: begin w.ctrl.ld_reg = 4'b1000;                   w.next = 4'd4; end
            4'd4: begin w.ctrl.ld_reg = 4'b0100; w.ctrl.ld_f = 1'b1;   w.next = 4'd5; end
            4'd5: begin w.ctrl.done = 1'b1;                        w.next = IDLE_ADDR; end
            default: begin w.ctrl.wait_start = 1'b1;               w.next = IDLE_ADDR; end
        endcase
        return w;
    endfunction

    // Combinational read port
    always_comb word = lookup(addr);
endmodule

// File: rtl/seqcalc_seq.sv
// Sequencer: holds the microprogram counter and steps it by the next field.
// Assumes start is only honoured at words flagged wait_start.
module seqcalc_seq
    import seqcalc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  uword_t        word,
    output logic [AW-1:0] upc
);
    logic [AW-1:0] upc_nxt;

    // Choose next address: stall in idle without start
    always_comb upc_nxt = (word.ctrl.wait_start && !start) ? upc : word.next;

    // Microprogram counter register
    always_ff @(posedge clk) begin
        if (!rst_n) upc <= IDLE_ADDR;
        else        upc <= upc_nxt;
    end
endmodule

// File: rtl/seqcalc_dp.sv
// Datapath: four working registers, one adder, one multiplier, an R3 input mux
// and a wide result register. Assumes at most one add and one multiply per step.
module seqcalc_dp
    import seqcalc_pkg::*;
#(
    parameter int W = DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  ctrl_t          ctrl,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [W-1:0]   e,
    output logic [2*W-1:0] f
);
    localparam int PW = 2 * W;

    logic [W-1:0]  regs  [NREG];
    logic [W-1:0]  wdata [NREG];
    logic [W-1:0]  sum;
    logic [PW-1:0] prod;
    logic [W-1:0]  r3_in;

    // Shared functional units read fixed register slots
    always_comb begin
        sum  = regs[0] + regs[1];
        prod = PW'(regs[2]) * PW'(regs[3]);
    end

    // R3 source select: adder when sel_add, multiplier low half otherwise
    always_comb r3_in = ctrl.sel_add ? sum : prod[W-1:0];

    // Write data routing per register slot
    always_comb begin
        wdata[0] = a;
        wdata[1] = b;
        wdata[2] = r3_in;
        wdata[3] = e;
    end

    // Register file with per-slot load enables
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n)              regs[i] <= '0;
            else if (ctrl.ld_reg[i]) regs[i] <= wdata[i];
        end
    end

    // Wide result capture on the multiply step
    always_ff @(posedge clk) begin
        if (!rst_n)         f <= '0;
        else if (ctrl.ld_f) f <= prod;
    end
endmodule

// File: rtl/seqcalc_top.sv
// Top: microcoded controller sequencing the shared datapath to form E*(A+B).
// Assumes operands held per the capture steps; done is decoded from the ROM.
module seqcalc_top
    import seqcalc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic [DW-1:0]   e,
    output logic            done,
    output logic [2*DW-1:0] f
);
    logic [AW-1:0] upc;
    uword_t        word;

    seqcalc_rom i_rom (.addr(upc), .word(word));

    seqcalc_seq i_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .word(word), .upc(upc)
    );

    seqcalc_dp #(.W(DW)) i_dp (
        .clk(clk), .rst_n(rst_n), .ctrl(word.ctrl),
        .a(a), .b(b), .e(e), .f(f)
    );

    // Completion flag straight from the current control word
    always_comb done = word.ctrl.done;
endmodule

// File: rtl/seqcalc_chk.sv
// Checker: temporal properties of the multiply-of-sum block, bound to the top.
module seqcalc_chk
    import seqcalc_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            done,
    input logic [2*DW-1:0] f,
    input logic [AW-1:0]   upc
);
    // R1: reset drives idle, cleared result, no done
    p_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (upc == IDLE_ADDR && f == '0 && !done));

    // R2: idle without start stays idle
    p_idle_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == IDLE_ADDR && !start) |=> upc == IDLE_ADDR);

    // R3: done only follows the multiply step
    p_done_after_mul: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(upc) == 4'd4);

    // R5: done lasts one cycle
    p_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: result changes only at the multiply step
    p_f_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (upc != 4'd4) |=> $stable(f));

    // R7: start outside idle does not begin a run
    p_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (upc != IDLE_ADDR && start) |=> upc != 4'd1);
endmodule

bind seqcalc_top seqcalc_chk i_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .f(f), .upc(upc)
);

// File: tb/test_seqcalc_top.sv
module test_seqcalc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  a = '0, b = '0, e = '0;
    logic        done;
    logic [15:0] f;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    seqcalc_top i_seqcalc_top (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a(a), .b(b), .e(e), .done(done), .f(f)
    );

    // {a, b, e}
    localparam logic [23:0] VEC [8] = '{
        {8'd3,   8'd4,   8'd5},
        {8'd0,   8'd0,   8'd9},
        {8'd255, 8'd0,   8'd255},
        {8'd200, 8'd100, 8'd7},
        {8'd128, 8'd128, 8'd200},
        {8'd1,   8'd254, 8'd1},
        {8'd17,  8'd34,  8'd0},
        {8'd250, 8'd10,  8'd255}
    };

    function automatic logic [15:0] model(input logic [7:0] x, input logic [7:0] y,
                                          input logic [7:0] z);
        logic [7:0] s;
        s = x + y;
        return 16'(s) * 16'(z);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One run; scramble changes operands after their capture edges
    task automatic run(input logic [7:0] x, input logic [7:0] y, input logic [7:0] z,
                       input bit scramble, input bit busy_start, input string req);
        int early;
        early = 0;
        @(negedge clk);
        a = x; b = y; e = z; start = 1'b1;
        @(negedge clk);                        // edge 1 sampled start
        start = 1'b0;
        for (int i = 2; i <= 4; i++) begin
            @(negedge clk);                    // edge i passed
            if (done) early++;
            if (busy_start && i == 2) start = 1'b1;
            if (busy_start && i == 3) start = 1'b0;
            if (scramble && i == 2) begin a = ~x; b = x ^ 8'h5a; end
            if (scramble && i == 4) e = ~z;
        end
        chk(early == 0, "R2 done low during run", early, 0);
        @(negedge clk);                        // edge 5 passed
        chk(done == 1'b1, {req, " done"}, done, 1);
        chk(f == model(x, y, z), {req, " result"}, f, model(x, y, z));
    endtask

    initial begin
        logic [15:0] held;
        int extra;
        int gap;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && f == 16'd0, "R1 reset state", {done, f}, 0);
        rst_n = 1'b1;
        // R2: idle without start
        extra = 0;
        repeat (8) begin @(negedge clk); if (done) extra++; end
        chk(extra == 0, "R2 idle no start", extra, 0);

        // R3 R4: table of vectors
        for (int k = 0; k < 8; k++)
            run(VEC[k][23:16], VEC[k][15:8], VEC[k][7:0], 1'b0, 1'b0, "R3 R4 vector");

        // R5 R6: pulse width and hold
        run(8'd9, 8'd6, 8'd11, 1'b0, 1'b0, "R3");
        held = f;
        @(negedge clk);
        chk(done == 1'b0, "R5 done one cycle", done, 0);
        a = 8'd77; b = 8'd88; e = 8'd99;
        repeat (5) @(negedge clk);
        chk(f == held, "R6 f holds", f, held);

        // R8: operand changes after capture ignored
        run(8'd20, 8'd30, 8'd40, 1'b1, 1'b0, "R8 capture timing");

        // R7: start mid-run ignored
        run(8'd5, 8'd5, 8'd5, 1'b0, 1'b1, "R7 busy start run");
        held = f;
        extra = 0;
        repeat (8) begin @(negedge clk); if (done) extra++; end
        chk(extra == 0, "R7 busy start no extra run", extra, 0);

        // R7: start in the done cycle ignored
        run(8'd12, 8'd13, 8'd2, 1'b0, 1'b0, "R7 pre");
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        held = f;
        extra = 0;
        repeat (8) begin @(negedge clk); if (done) extra++; end
        chk(extra == 0, "R7 done-cycle start ignored", extra, 0);
        chk(f == held, "R7 f unchanged", f, held);

        // R9: start held high gives 6-cycle period
        a = 8'd2; b = 8'd3; e = 8'd4;
        @(negedge clk);
        start = 1'b1;
        while (!done) @(negedge clk);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!done && gap < 20);
        chk(gap == 6, "R9 back-to-back period", gap, 6);
        chk(f == 16'd20, "R9 result", f, 20);
        start = 1'b0;
        repeat (8) @(negedge clk);

        // R1: reset mid-run
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && f == 16'd0, "R1 mid-run reset clears", {done, f}, 0);
        rst_n = 1'b1;
        extra = 0;
        repeat (8) begin @(negedge clk); if (done) extra++; end
        chk(extra == 0, "R1 idle after reset", extra, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #(8 * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule